// File: doc/BRIEF.md
# Two-Way Instruction Cache with Command and Array-Inspection Registers

This block sits between an instruction fetch unit and a burst-capable memory port. It holds 128 sets of two ways, each line four 32-bit words. A fetch presents a word address and holds it until acknowledged. A hit is answered in the same cycle. A miss fills the least-recently-used way of the set with a four-beat burst, and the fetch is then answered from the cache. While the cache is disabled, every fetch is passed to memory as a single-word read, and nothing is stored.

A small register port drives the block. The control register takes enable and disable commands and shows the enable state. The address register points at one entry of the tag array or the data array. The data register then returns the chosen word, or the tag with its valid, lock and LRU bits. A write to the control or address register starts a command that runs for two cycles. During that time `stall_o` is high and new fetches are held off.

Top module: `icache_ctl`

## Requirements
- R1: After reset the cache is disabled (control read returns 0), `stall_o` and `mem_req_o` are low, and every line is invalid, so the first enabled fetch to any set misses.
- R2: While disabled, a fetch issues one `mem_req_o` with `mem_burst_o`=0 at the exact fetch address. It returns `mem_rdata_i` on `fetch_data_o` with `fetch_ack_o`, and allocates nothing: a repeat fetch, or a later enabled fetch to that address, goes to memory again.
- R3: Register select is `reg_sel_i` 0 = control, 1 = address, 2 = data. Writing command 3'b001 in control bits [2:0] enables the cache and 3'b010 disables it. Any other code leaves the state unchanged. A control read returns the enable state in bit 31, with all other bits zero.
- R4: A write to the control or address register raises `stall_o` for exactly the two cycles that follow the write cycle.
- R5: While `stall_o` is high, no fetch is acknowledged from the idle state and no memory request starts. A fetch held across the stall is served afterwards.
- R6: An enabled miss issues one request with `mem_burst_o`=1 and the address word bits at 0. It accepts four beats in word order into the LRU way of the set, then answers the fetch.
- R7: An enabled hit raises `fetch_ack_o` in the cycle of the request with the cached word, and makes no memory request.
- R8: Each set has an LRU bit naming the way to replace next, cleared at reset. A fill or a hit sets it to the other way.
- R9: Disabling keeps tags, data and valid bits. After re-enabling, earlier lines hit again.
- R10: Address register fields (LSB-0 numbering): bit 13 selects the array (1 tag, 0 data), bit 12 the way, bits [10:4] the set, bits [3:2] the word. Reading it back returns these fields, with all other bits zero.
- R11: After an address write that selects the data array, the data register returns the selected word of that way and set.
- R12: After an address write that selects the tag array, the data register returns the tag in bits [31:11], valid in bit 9, lock (always 0) in bit 8 and the set's LRU bit in bit 7, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request, held with its address until acknowledged |
| fetch_addr_i | input | 30 | Word address of the fetch |
| fetch_ack_o | output | 1 | Fetch answered this cycle |
| fetch_data_o | output | 32 | Instruction word returned |
| stall_o | output | 1 | Register command in progress, fetches held off |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_addr_o | output | 30 | Word address of the request |
| mem_burst_o | output | 1 | 1 = four-beat line read, 0 = single word |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 32 | Read beat data |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |

## Verification
A wrong LRU bit or a lost valid bit shows up at the memory port at the next fetch to that set, as a burst request where none should occur or a line refilled into the wrong way. Later hit and miss results expose it, and so does a direct tag read through the data register. A stale enable state shows within one fetch through the burst flag. A miscounted command length shows in the first cycle where `stall_o` disagrees with the two-cycle window, or where an acknowledge appears inside that window.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADR  = 2'd1;
  localparam logic [1:0] SEL_DAT  = 2'd2;

  localparam logic [2:0] CMD_EN  = 3'b001;
  localparam logic [2:0] CMD_DIS = 3'b010;

  // address register fields, LSB-0
  localparam int ADR_ARR_BIT  = 13;
  localparam int ADR_WAY_BIT  = 12;
  localparam int ADR_SET_LSB  = 4;
  localparam int ADR_WORD_LSB = 2;

  // data register fields on a tag read
  localparam int DAT_VLD_BIT = 9;
  localparam int DAT_LCK_BIT = 8;
  localparam int DAT_LRU_BIT = 7;
  localparam int STAT_EN_BIT = 31;

  typedef enum logic [1:0] {FS_IDLE, FS_FILL, FS_BYPASS} fill_st_e;
endpackage

// File: rtl/icache_arrays.sv
`timescale 1ns/1ps
module icache_arrays #(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  look_set_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  input  logic [WORD_W-1:0] look_word_i,
  output logic [1:0]        hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              lru_o,
  input  logic              wr_en_i,
  input  logic              wr_way_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tag_we_i,
  input  logic              lru_we_i,
  input  logic              lru_val_i,
  input  logic              dbg_way_i,
  input  logic [SET_W-1:0]  dbg_set_i,
  input  logic [WORD_W-1:0] dbg_word_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [TAG_W-1:0]  dbg_tag_o,
  output logic              dbg_vld_o,
  output logic              dbg_lru_o
);
  logic [1:0][DATA_W-1:0] way_data, dbg_data_w;
  logic [1:0][TAG_W-1:0]  dbg_tag_w;
  logic [1:0]             dbg_vld_w;
  logic [SETS-1:0]        lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] data_q [SETS*WORDS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   vld_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i == 1'(w)) data_q[{look_set_i, wr_word_i}] <= wr_data_i;
      if (tag_we_i && wr_way_i == 1'(w)) tag_q[look_set_i] <= look_tag_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else if (tag_we_i && wr_way_i == 1'(w)) vld_q[look_set_i] <= 1'b1;
    end

    assign hit_o[w]      = vld_q[look_set_i] && (tag_q[look_set_i] == look_tag_i);
    assign way_data[w]   = data_q[{look_set_i, look_word_i}];
    assign dbg_data_w[w] = data_q[{dbg_set_i, dbg_word_i}];
    assign dbg_tag_w[w]  = tag_q[dbg_set_i];
    assign dbg_vld_w[w]  = vld_q[dbg_set_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (lru_we_i) lru_q[look_set_i] <= lru_val_i;
  end

  assign hit_data_o = hit_o[1] ? way_data[1] : way_data[0];
  assign lru_o      = lru_q[look_set_i];
  assign dbg_data_o = dbg_data_w[dbg_way_i];
  assign dbg_tag_o  = dbg_tag_w[dbg_way_i];
  assign dbg_vld_o  = dbg_vld_w[dbg_way_i];
  assign dbg_lru_o  = lru_q[dbg_set_i];
endmodule

// File: rtl/icache_regs.sv
`timescale 1ns/1ps
module icache_regs
  import icache_pkg::*;
#(
  parameter int SET_W  = 7,
  parameter int WORD_W = 2,
  parameter int TAG_W  = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              en_o,
  output logic              busy_o,
  output logic              dbg_way_o,
  output logic [SET_W-1:0]  dbg_set_o,
  output logic [WORD_W-1:0] dbg_word_o,
  input  logic [DATA_W-1:0] dbg_data_i,
  input  logic [TAG_W-1:0]  dbg_tag_i,
  input  logic              dbg_vld_i,
  input  logic              dbg_lru_i
);
  logic [1:0]       cnt_q;
  logic [2:0]       cmd_q;
  logic             ctrl_pend_q, en_q, arr_q;
  logic [REG_W-1:0] dat_q, dat_next, adr_view;
  logic             wr_cmd;
  logic             unused_wdata;

  assign wr_cmd       = reg_we_i && (reg_sel_i == SEL_CTRL || reg_sel_i == SEL_ADR);
  assign unused_wdata = ^{reg_wdata_i[31:14], reg_wdata_i[11]};

  always_comb begin
    dat_next = REG_W'(dbg_data_i);
    if (arr_q) begin
      dat_next = '0;
      dat_next[REG_W-1 -: TAG_W] = dbg_tag_i;
      dat_next[DAT_VLD_BIT]      = dbg_vld_i;
      dat_next[DAT_LCK_BIT]      = 1'b0;
      dat_next[DAT_LRU_BIT]      = dbg_lru_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; cmd_q <= '0; ctrl_pend_q <= 1'b0; en_q <= 1'b0;
      arr_q <= 1'b0; dbg_way_o <= 1'b0; dbg_set_o <= '0; dbg_word_o <= '0; dat_q <= '0;
    end else begin
      if (wr_cmd) begin
        cnt_q       <= 2'd2;
        ctrl_pend_q <= (reg_sel_i == SEL_CTRL);
        if (reg_sel_i == SEL_CTRL) cmd_q <= reg_wdata_i[2:0];
        else begin
          arr_q      <= reg_wdata_i[ADR_ARR_BIT];
          dbg_way_o  <= reg_wdata_i[ADR_WAY_BIT];
          dbg_set_o  <= reg_wdata_i[ADR_SET_LSB +: SET_W];
          dbg_word_o <= reg_wdata_i[ADR_WORD_LSB +: WORD_W];
        end
      end else if (cnt_q != 2'd0) begin
        cnt_q <= cnt_q - 2'd1;
      end
      // execute step: first stall cycle
      if (cnt_q == 2'd2) begin
        if (ctrl_pend_q && cmd_q == CMD_EN)  en_q <= 1'b1;
        if (ctrl_pend_q && cmd_q == CMD_DIS) en_q <= 1'b0;
        dat_q <= dat_next;
      end
    end
  end

  always_comb begin
    adr_view = '0;
    adr_view[ADR_ARR_BIT]              = arr_q;
    adr_view[ADR_WAY_BIT]              = dbg_way_o;
    adr_view[ADR_SET_LSB +: SET_W]     = dbg_set_o;
    adr_view[ADR_WORD_LSB +: WORD_W]   = dbg_word_o;
    unique case (reg_sel_i)
      SEL_CTRL: begin reg_rdata_o = '0; reg_rdata_o[STAT_EN_BIT] = en_q; end
      SEL_ADR:  reg_rdata_o = adr_view;
      SEL_DAT:  reg_rdata_o = dat_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign busy_o = (cnt_q != 2'd0);
endmodule

// File: rtl/icache_fill.sv
`timescale 1ns/1ps
module icache_fill
  import icache_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              busy_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ack_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_burst_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [1:0]        hit_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              lru_i,
  output logic              wr_en_o,
  output logic              wr_way_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic              tag_we_o,
  output logic              lru_we_o,
  output logic              lru_val_o
);
  fill_st_e          st_q;
  logic              way_q;
  logic [WORD_W-1:0] beat_q;
  logic              last_beat;

  assign last_beat = (beat_q == WORD_W'(WORDS-1));
  assign wr_way_o  = way_q;
  assign wr_word_o = beat_q;

  always_comb begin
    fetch_ack_o  = 1'b0;
    fetch_data_o = hit_data_i;
    mem_req_o    = 1'b0;
    mem_burst_o  = en_i;
    mem_addr_o   = en_i ? {fetch_addr_i[ADDR_W-1:WORD_W], {WORD_W{1'b0}}} : fetch_addr_i;
    wr_en_o      = 1'b0;
    tag_we_o     = 1'b0;
    lru_we_o     = 1'b0;
    lru_val_o    = 1'b0;
    unique case (st_q)
      FS_IDLE: if (fetch_req_i && !busy_i) begin
        if (en_i && |hit_i) begin
          fetch_ack_o = 1'b1;
          lru_we_o    = 1'b1;
          lru_val_o   = !hit_i[1];
        end else begin
          mem_req_o = 1'b1;
        end
      end
      FS_FILL: if (mem_rvalid_i) begin
        wr_en_o = 1'b1;
        if (last_beat) begin
          tag_we_o  = 1'b1;
          lru_we_o  = 1'b1;
          lru_val_o = !way_q;
        end
      end
      FS_BYPASS: if (mem_rvalid_i) begin
        fetch_ack_o  = 1'b1;
        fetch_data_o = mem_rdata_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FS_IDLE; way_q <= 1'b0; beat_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (mem_req_o) begin
          st_q   <= en_i ? FS_FILL : FS_BYPASS;
          way_q  <= lru_i;
          beat_q <= '0;
        end
        FS_FILL: if (mem_rvalid_i) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) st_q <= FS_IDLE;
        end
        FS_BYPASS: if (mem_rvalid_i) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_ctl.sv
`timescale 1ns/1ps
module icache_ctl
  import icache_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ack_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_burst_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic              en_w, busy_w, lru_w;
  logic [1:0]        hit_w;
  logic [DATA_W-1:0] hit_data_w, dbg_data_w;
  logic              wr_en_w, wr_way_w, tag_we_w, lru_we_w, lru_val_w;
  logic [WORD_W-1:0] wr_word_w, dbg_word_w;
  logic              dbg_way_w, dbg_vld_w, dbg_lru_w;
  logic [SET_W-1:0]  dbg_set_w;
  logic [TAG_W-1:0]  dbg_tag_w;

  icache_arrays #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arrays (
    .clk_i, .rst_ni,
    .look_set_i  (fetch_addr_i[WORD_W +: SET_W]),
    .look_tag_i  (fetch_addr_i[ADDR_W-1 -: TAG_W]),
    .look_word_i (fetch_addr_i[WORD_W-1:0]),
    .hit_o       (hit_w),
    .hit_data_o  (hit_data_w),
    .lru_o       (lru_w),
    .wr_en_i     (wr_en_w),
    .wr_way_i    (wr_way_w),
    .wr_word_i   (wr_word_w),
    .wr_data_i   (mem_rdata_i),
    .tag_we_i    (tag_we_w),
    .lru_we_i    (lru_we_w),
    .lru_val_i   (lru_val_w),
    .dbg_way_i   (dbg_way_w),
    .dbg_set_i   (dbg_set_w),
    .dbg_word_i  (dbg_word_w),
    .dbg_data_o  (dbg_data_w),
    .dbg_tag_o   (dbg_tag_w),
    .dbg_vld_o   (dbg_vld_w),
    .dbg_lru_o   (dbg_lru_w)
  );

  icache_regs #(.SET_W(SET_W), .WORD_W(WORD_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .en_o       (en_w),
    .busy_o     (busy_w),
    .dbg_way_o  (dbg_way_w),
    .dbg_set_o  (dbg_set_w),
    .dbg_word_o (dbg_word_w),
    .dbg_data_i (dbg_data_w),
    .dbg_tag_i  (dbg_tag_w),
    .dbg_vld_i  (dbg_vld_w),
    .dbg_lru_i  (dbg_lru_w)
  );

  icache_fill #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_fill (
    .clk_i, .rst_ni,
    .en_i        (en_w),
    .busy_i      (busy_w),
    .fetch_req_i, .fetch_addr_i, .fetch_ack_o, .fetch_data_o,
    .mem_req_o, .mem_addr_o, .mem_burst_o, .mem_rvalid_i, .mem_rdata_i,
    .hit_i       (hit_w),
    .hit_data_i  (hit_data_w),
    .lru_i       (lru_w),
    .wr_en_o     (wr_en_w),
    .wr_way_o    (wr_way_w),
    .wr_word_o   (wr_word_w),
    .tag_we_o    (tag_we_w),
    .lru_we_o    (lru_we_w),
    .lru_val_o   (lru_val_w)
  );

  assign stall_o = busy_w;
endmodule

// File: rtl/icache_chk.sv
`timescale 1ns/1ps
module icache_chk #(
  parameter int WORD_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [2:0]        cmd_i,
  input logic              stall_o,
  input logic              en_i,
  input logic              fetch_req_i,
  input logic              fetch_ack_o,
  input logic              mem_req_o,
  input logic              mem_burst_o,
  input logic [WORD_W-1:0] mem_word_i
);
  p_cmd_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i != 2'd2) |=> stall_o);

  p_stall_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |=> stall_o);

  p_stall_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !mem_req_o);

  p_burst_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o) |-> (mem_word_i == '0));

  p_single_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_ack_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ack_o |-> fetch_req_i);

  p_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_i && reg_sel_i == 2'd0 && cmd_i == 3'b001, 2) |-> en_i);

  p_disable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_i && reg_sel_i == 2'd0 && cmd_i == 3'b010, 2) |-> !en_i);
endmodule

bind icache_ctl icache_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .cmd_i       (reg_wdata_i[2:0]),
  .stall_o     (stall_o),
  .en_i        (en_w),
  .fetch_req_i (fetch_req_i),
  .fetch_ack_o (fetch_ack_o),
  .mem_req_o   (mem_req_o),
  .mem_burst_o (mem_burst_o),
  .mem_word_i  (mem_addr_o[WORD_W-1:0])
);

// File: tb/tb_icache_ctl.sv
`timescale 1ns/1ps
module tb_icache_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [29:0] fetch_addr_i = '0;
  logic        fetch_ack_o;
  logic [31:0] fetch_data_o;
  logic        stall_o;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic        mem_burst_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  logic [29:0] last_addr = '0;
  logic        last_burst = 1'b0;
  logic [31:0] exp_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  icache_ctl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i, .fetch_addr_i, .fetch_ack_o, .fetch_data_o, .stall_o,
    .mem_req_o, .mem_addr_o, .mem_burst_o, .mem_rvalid_i, .mem_rdata_i,
    .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o
  );

  function automatic logic [31:0] memval(logic [29:0] a);
    return {a, 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [29:0] wa(int tag, int set, int word);
    return 30'((tag << 9) | (set << 2) | word);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && mem_req_o) begin
        logic [29:0] a;
        int nb;
        req_cnt++;
        a = mem_addr_o; last_addr = mem_addr_o; last_burst = mem_burst_o;
        nb = mem_burst_o ? 4 : 1;
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
          @(negedge clk); #1;
          mem_rvalid_i = 1'b1; mem_rdata_i = memval(a + 30'(i));
        end
        @(negedge clk); #1;
        mem_rvalid_i = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      if (fetch_ack_o && fetch_req_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected ack", fetch_data_o, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(fetch_data_o == e, "R6/R7", "fetch data", fetch_data_o, e);
        end
      end
    end
  end

  task automatic fetch(logic [29:0] a, bit exp_req, bit exp_burst, string req);
    int c0;
    c0 = req_cnt;
    @(negedge clk);
    fetch_req_i = 1'b1; fetch_addr_i = a;
    exp_q.push_back(memval(a));
    forever begin
      #3;
      if (fetch_ack_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    fetch_req_i = 1'b0;
    chk((req_cnt - c0) == int'(exp_req), req, "memory request count", 32'(req_cnt - c0), 32'(exp_req));
    if (exp_req) begin
      chk(last_burst == exp_burst, req, "burst flag", 32'(last_burst), 32'(exp_burst));
      chk(last_addr == (exp_burst ? {a[29:2], 2'b00} : a), req, "request address",
          32'(last_addr), 32'(exp_burst ? {a[29:2], 2'b00} : a));
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
    #3 chk(stall_o == 1'b1, "R4", "stall cycle 1", 32'(stall_o), 32'd1);
    @(negedge clk);
    #3 chk(stall_o == 1'b1, "R4", "stall cycle 2", 32'(stall_o), 32'd1);
    @(negedge clk);
    #3 chk(stall_o == 1'b0, "R4", "stall released", 32'(stall_o), 32'd0);
  endtask

  task automatic reg_rd(logic [1:0] sel, logic [31:0] exp, string req, string what);
    @(negedge clk);
    reg_sel_i = sel;
    #1 chk(reg_rdata_o == exp, req, what, reg_rdata_o, exp);
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "WDOG", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  localparam int S  = 5;
  localparam int S2 = 9;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk(stall_o == 1'b0 && mem_req_o == 1'b0, "R1", "stall/req after reset",
           {30'd0, stall_o, mem_req_o}, 32'h0);
    reg_rd(2'd0, 32'h0, "R1", "control after reset");

    // R2 disabled: single word, no allocation
    fetch(wa(2, S2, 1), 1'b1, 1'b0, "R2");
    fetch(wa(2, S2, 1), 1'b1, 1'b0, "R2");

    // R3 enable
    reg_wr(2'd0, 32'h1);
    reg_rd(2'd0, 32'h8000_0000, "R3", "enable status");

    // R2/R1 nothing allocated while disabled, lines invalid after reset
    fetch(wa(2, S2, 1), 1'b1, 1'b1, "R1");

    // R6/R7/R8 LRU sequence on set S
    fetch(wa(3, S, 2), 1'b1, 1'b1, "R6");
    fetch(wa(3, S, 3), 1'b0, 1'b0, "R7");
    fetch(wa(7, S, 0), 1'b1, 1'b1, "R8");
    fetch(wa(3, S, 1), 1'b0, 1'b0, "R8");
    fetch(wa(9, S, 0), 1'b1, 1'b1, "R8");
    fetch(wa(3, S, 0), 1'b0, 1'b0, "R8");
    fetch(wa(7, S, 0), 1'b1, 1'b1, "R8");
    fetch(wa(7, S, 3), 1'b0, 1'b0, "R8");
    fetch(wa(3, S, 0), 1'b0, 1'b0, "R8");

    // R12 tag reads: way0 holds tag 3, way1 tag 7, LRU = 1
    reg_wr(2'd1, 32'h0000_2050);
    reg_rd(2'd2, 32'h0000_1A80, "R12", "tag read way0");
    reg_wr(2'd1, 32'h0000_3050);
    reg_rd(2'd2, 32'h0000_3A80, "R12", "tag read way1");

    // R11 data reads
    reg_wr(2'd1, 32'h0000_1058);
    reg_rd(2'd2, memval(wa(7, S, 2)), "R11", "data read way1 word2");
    reg_wr(2'd1, 32'h0000_0054);
    reg_rd(2'd2, memval(wa(3, S, 1)), "R11", "data read way0 word1");

    // R10 address readback, reserved bits dropped
    reg_wr(2'd1, 32'hFFFF_C000 | 32'h0000_0803 | 32'h0000_1058);
    reg_rd(2'd1, 32'h0000_1058, "R10", "address readback");

    // R5 fetch held during command stall
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = 2'd1; reg_wdata_i = 32'h0000_1058;
    @(negedge clk);
    reg_we_i = 1'b0; fetch_req_i = 1'b1; fetch_addr_i = wa(3, S, 0);
    exp_q.push_back(memval(wa(3, S, 0)));
    #3 chk(!fetch_ack_o && !mem_req_o && stall_o, "R5", "no ack in stall 1",
           {29'd0, fetch_ack_o, mem_req_o, stall_o}, 32'h1);
    @(negedge clk);
    #3 chk(!fetch_ack_o && !mem_req_o && stall_o, "R5", "no ack in stall 2",
           {29'd0, fetch_ack_o, mem_req_o, stall_o}, 32'h1);
    @(negedge clk);
    #3 chk(fetch_ack_o && !stall_o, "R5", "served after stall",
           {30'd0, fetch_ack_o, stall_o}, 32'h2);
    @(negedge clk);
    fetch_req_i = 1'b0;

    // R3 unknown code has no effect
    reg_wr(2'd0, 32'h3);
    reg_rd(2'd0, 32'h8000_0000, "R3", "unknown command ignored");

    // R3/R9 disable keeps contents
    reg_wr(2'd0, 32'h2);
    reg_rd(2'd0, 32'h0, "R3", "disable status");
    fetch(wa(3, S, 0), 1'b1, 1'b0, "R2");
    reg_wr(2'd0, 32'h1);
    fetch(wa(7, S, 1), 1'b0, 1'b0, "R9");
    fetch(wa(3, S, 2), 1'b0, 1'b0, "R9");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule